// File: doc/BRIEF.md
# SDRAM Auto-Precharge Interrupt Tracker

This block follows the state of every bank of an SDRAM device, one registered command per clock. It targets a single situation that plain bank trackers get wrong: a write burst issued with auto precharge on one bank is cut short by a read or a write to another bank. The tracker then stops capturing data for the first bank and starts that bank's write-recovery countdown at the interrupting command. The precharge then runs alongside the new access, and the bank goes back to idle.

A controller or a synthesizable memory model places it next to its command decoder. Per-bank outputs give the state code, a ready flag and a data-capture enable. A shared flag marks the clocks that carry read data. Another shared flag pulses whenever a command is refused.

Top module: `sdram_ap_tracker`

## Requirements
- R1: While reset is asserted, every bank reports state 0 (idle), every ready flag is 1, and wr_capture, rd_valid and proto_err are all 0.
- R2: Command codes are 0 = no-op, 1 = activate, 2 = read, 3 = write. State codes are 0 idle, 1 open, 2 write burst, 3 write recovery, 4 precharging. An activate to an idle bank shows state 1 on the next clock.
- R3: A write accepted by an open bank asserts that bank's wr_capture in the command clock and in the following BURST_LEN-1 clocks. Without auto precharge the bank then shows state 1 again.
- R4: An uninterrupted auto-precharge write shows state 3 for T_WR clocks after its last beat, then state 4 for T_RP clocks. The bank is idle BURST_LEN+T_WR+T_RP clocks after the write command.
- R5: An accepted read or write to another bank, k clocks after an auto-precharge write (1 <= k <= BURST_LEN-1), ends capture for the written bank in that clock, so it captures exactly k beats. At most one wr_capture bit is high in any clock.
- R6: The interrupted bank shows state 3 from clock k+1 for T_WR clocks, then state 4 for T_RP clocks. It is idle at clock k+1+T_WR+T_RP.
- R7: An interrupting write captures its full burst of BURST_LEN beats on its own bank, starting in its command clock.
- R8: rd_valid is high for BURST_LEN clocks, starting CAS_LAT clocks after an accepted read.
- R9: A command to a bank in state 3 or 4, an activate to a non-idle bank, or a read or write to an idle bank raises proto_err in that clock. The command has no other effect: no capture, no read data, no change to the bank's countdown.
- R10: A bank's ready flag is 1 exactly while it is in state 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_code | input | 2 | Registered command code |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| cmd_ap | input | 1 | Auto-precharge request for a write |
| bank_state | output | 3*NUM_BANKS | State code per bank, bank b at bits 3b+2..3b |
| bank_ready | output | NUM_BANKS | Bank is idle or open |
| wr_capture | output | NUM_BANKS | Capture the write beat on the data bus for this bank |
| rd_valid | output | 1 | Read data is on the bus this clock |
| proto_err | output | 1 | The command in this clock was refused |

## Verification
The bench builds the tracker with four banks, a burst of 4, T_WR of 2, T_RP of 3 and a CAS latency of 3. With these values the interrupting command can land on each beat position from 1 to 3, so both read and write cuts are exercised early, mid-burst and on the final beat. The recovery and precharge windows are short enough that the idle clock can be checked exactly against the formula. A write aimed at a bank that is still recovering falls inside that short window, and the bench checks that the refused write leaves the bank's return to idle unchanged.

// File: rtl/sdram_apt_pkg.sv
package sdram_apt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_OPEN   = 3'd1,
    BK_WBURST = 3'd2,
    BK_WREC   = 3'd3,
    BK_PRECH  = 3'd4
  } bank_st_e;
endpackage

// File: rtl/sdram_apt_bank.sv
module sdram_apt_bank
  import sdram_apt_pkg::*;
#(
  parameter int IDX       = 0,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  input  logic              other_rw,
  output bank_st_e          state_o,
  output logic              ready_o,
  output logic              cap_o,
  output logic              acc_rw_o,
  output logic              err_o
);
  localparam int CNT_MAX = (T_WR > T_RP) ? T_WR : T_RP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BEAT_W  = $clog2(BURST_LEN + 1);

  bank_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              ap_q, ap_d;
  logic              sel, is_rw, rw_ok, cut, new_wr, upd_en;

  always_comb begin
    sel      = (cmd_bank == BANK_W'(IDX));
    is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    rw_ok    = (st_q == BK_OPEN) || ((st_q == BK_WBURST) && !ap_q);
    acc_rw_o = sel && is_rw && rw_ok;
    err_o    = sel && ((is_rw && !rw_ok) || ((cmd == CMD_ACT) && (st_q != BK_IDLE)));
    cut      = other_rw && (st_q == BK_WBURST);
    new_wr   = acc_rw_o && (cmd == CMD_WR);
    cap_o    = new_wr || ((st_q == BK_WBURST) && !cut && !acc_rw_o);
    ready_o  = (st_q == BK_IDLE) || (st_q == BK_OPEN);
    state_o  = st_q;
    upd_en   = (st_q != BK_IDLE) || (sel && (cmd == CMD_ACT));
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    beat_d = beat_q;
    ap_d   = ap_q;
    case (st_q)
      BK_IDLE: if (sel && (cmd == CMD_ACT)) st_d = BK_OPEN;
      BK_OPEN, BK_WBURST: begin
        if (new_wr) begin
          ap_d   = cmd_ap;
          beat_d = BEAT_W'(1);
          if (BURST_LEN == 1) begin
            st_d  = cmd_ap ? BK_WREC : BK_OPEN;
            cnt_d = CNT_W'(T_WR - 1);
          end else begin
            st_d = BK_WBURST;
          end
        end else if (acc_rw_o) begin
          st_d = BK_OPEN;
        end else if (st_q == BK_WBURST) begin
          if (cut || (beat_q == BEAT_W'(BURST_LEN - 1))) begin
            st_d  = ap_q ? BK_WREC : BK_OPEN;
            cnt_d = CNT_W'(T_WR - 1);
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      BK_WREC: begin
        if (cnt_q == '0) begin
          st_d  = BK_PRECH;
          cnt_d = CNT_W'(T_RP - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      BK_PRECH: begin
        if (cnt_q == '0) st_d = BK_IDLE;
        else cnt_d = cnt_q - CNT_W'(1);
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      ap_q   <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      ap_q   <= ap_d;
    end
  end

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && ((st_q == BK_IDLE) || (st_q == BK_OPEN)) |=> $stable(st_q));

  // R6
  cut_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cut && ap_q |=> (st_q == BK_WREC));

  // R4
  rec_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_WREC) |=> ((st_q == BK_WREC) || (st_q == BK_PRECH)));

  // R4
  prech_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_PRECH) |=> ((st_q == BK_PRECH) || (st_q == BK_IDLE)));
endmodule

// File: rtl/sdram_apt_rdpipe.sv
module sdram_apt_rdpipe #(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  output logic rd_valid
);
  localparam int LEFT_W = $clog2(BURST_LEN + 1);

  logic [CAS_LAT-1:0] sr_q, sr_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               pipe_en;

  generate
    if (CAS_LAT == 1) begin : g_cl1
      always_comb sr_d = rd_issue;
    end else begin : g_cln
      always_comb sr_d = {sr_q[CAS_LAT-2:0], rd_issue};
    end
  endgenerate

  always_comb begin
    if (sr_q[CAS_LAT-1])    left_d = LEFT_W'(BURST_LEN - 1);
    else if (left_q != '0)  left_d = left_q - LEFT_W'(1);
    else                    left_d = '0;
    pipe_en  = rd_issue || (sr_q != '0) || (left_q != '0);
    rd_valid = sr_q[CAS_LAT-1] || (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (pipe_en) begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end

  // R8
  rd_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> ($past(left_q) <= LEFT_W'(1)));
endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cmd_code,
  input  logic [BANK_W-1:0]      cmd_bank,
  input  logic                   cmd_ap,
  output logic [3*NUM_BANKS-1:0] bank_state,
  output logic [NUM_BANKS-1:0]   bank_ready,
  output logic [NUM_BANKS-1:0]   wr_capture,
  output logic                   rd_valid,
  output logic                   proto_err
);
  cmd_e                 cmd_t;
  logic [NUM_BANKS-1:0] acc_rw_v, err_v, other_rw_v;
  logic                 rd_issue;

  assign cmd_t     = cmd_e'(cmd_code);
  assign rd_issue  = (|acc_rw_v) && (cmd_t == CMD_RD);
  assign proto_err = |err_v;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bank_st_e st_b;
      assign other_rw_v[b] = |(acc_rw_v & ~(NUM_BANKS'(1) << b));
      assign bank_state[3*b +: 3] = st_b;
      sdram_apt_bank #(
        .IDX(b), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN), .T_WR(T_WR), .T_RP(T_RP)
      ) u_bank (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_t), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
        .other_rw(other_rw_v[b]), .state_o(st_b), .ready_o(bank_ready[b]),
        .cap_o(wr_capture[b]), .acc_rw_o(acc_rw_v[b]), .err_o(err_v[b])
      );
    end
  endgenerate

  sdram_apt_rdpipe #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .rd_valid(rd_valid)
  );

  // R5
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_capture));
endmodule

// File: tb/sdram_ap_tracker_bench.sv
module sdram_ap_tracker_bench;
  localparam int NB = 4, BL = 4, TWR = 2, TRP = 3, CL = 3;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cmd_code;
  logic [1:0]    cmd_bank;
  logic          cmd_ap;
  logic [3*NB-1:0] bank_state;
  logic [NB-1:0] bank_ready, wr_capture;
  logic          rd_valid, proto_err;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  sdram_ap_tracker #(.NUM_BANKS(NB), .BURST_LEN(BL), .T_WR(TWR), .T_RP(TRP), .CAS_LAT(CL))
  u_sdram_ap_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .bank_state(bank_state), .bank_ready(bank_ready), .wr_capture(wr_capture),
    .rd_valid(rd_valid), .proto_err(proto_err)
  );

  function automatic int st(int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int c, int b, bit ap);
    @(negedge clk);
    cmd_code = 2'(c);
    cmd_bank = 2'(b);
    cmd_ap   = ap;
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_code = 2'd0; cmd_bank = 2'd0; cmd_ap = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    for (int b = 0; b < NB; b++) chk("R1", "state in reset", st(b), 0);
    chk("R1", "ready in reset", int'(bank_ready), (1 << NB) - 1);
    chk("R1", "capture in reset", int'(wr_capture), 0);
    chk("R1", "rd_valid in reset", int'(rd_valid), 0);
    chk("R1", "proto_err in reset", int'(proto_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_activate(int b);
    tick(C_ACT, b, 1'b0);
    chk("R2", "state before activate edge", st(b), 0);
    tick(C_NOP, 0, 1'b0);
    chk("R2", "state after activate", st(b), 1);
    chk("R10", "ready when open", int'(bank_ready[b]), 1);
  endtask

  task automatic t_plain_write(int b);
    int caps = 0;
    for (int c = 0; c < 8; c++) begin
      tick(c == 0 ? C_WR : C_NOP, b, 1'b0);
      caps += int'(wr_capture[b]);
      if (c == 1) chk("R3", "state mid burst", st(b), 2);
      if (c == 4) chk("R3", "state after plain burst", st(b), 1);
    end
    chk("R3", "plain write beats", caps, BL);
  endtask

  task automatic t_ap_write_with_refusal(int b);
    int caps = 0, idle_at = -1, err5 = 0, rdv = 0;
    for (int c = 0; c < 16; c++) begin
      tick(c == 0 ? C_WR : (c == 5 ? C_WR : C_NOP), b, 1'b1);
      caps += int'(wr_capture[b]);
      rdv  += int'(rd_valid);
      if (c == 4) chk("R4", "recovery state", st(b), 3);
      if (c == 5) begin
        err5 = int'(proto_err);
        chk("R10", "ready during recovery", int'(bank_ready[b]), 0);
      end
      if (c == 6) chk("R4", "precharge state", st(b), 4);
      if (c > 0 && idle_at < 0 && st(b) == 0) begin
        idle_at = c;
        chk("R10", "ready when idle", int'(bank_ready[b]), 1);
      end
    end
    chk("R9", "write during recovery flagged", err5, 1);
    chk("R9", "beats incl refused write", caps, BL);
    chk("R4", "idle clock of uninterrupted AP write", idle_at, BL + TWR + TRP);
    chk("R9", "no read data", rdv, 0);
  endtask

  task automatic t_interrupt(int kind, int k, int n, int m);
    int cap_n = 0, cap_m = 0, idle_n = -1, rd_first = -1, rd_cnt = 0;
    string rq;
    if (st(n) == 0) t_activate(n);
    if (st(m) == 0) t_activate(m);
    rq = (kind == C_RD) ? "R8" : "R7";
    for (int c = 0; c < 22; c++) begin
      if (c == 0)      tick(C_WR, n, 1'b1);
      else if (c == k) tick(kind, m, kind == C_WR);
      else             tick(C_NOP, 0, 1'b0);
      cap_n += int'(wr_capture[n]);
      cap_m += int'(wr_capture[m]);
      if (rd_valid) begin
        rd_cnt++;
        if (rd_first < 0) rd_first = c;
      end
      if (c == k + 1) chk("R6", "interrupted bank in recovery", st(n), 3);
      if (c == k + 1 + TWR) chk("R6", "interrupted bank precharging", st(n), 4);
      if (c > 0 && idle_n < 0 && st(n) == 0) idle_n = c;
    end
    chk("R5", $sformatf("beats on cut bank k=%0d", k), cap_n, k);
    chk("R6", $sformatf("idle clock of cut bank k=%0d", k), idle_n, k + 1 + TWR + TRP);
    chk("R7", "beats on interrupting bank", cap_m, kind == C_WR ? BL : 0);
    chk(rq, "read valid count", rd_cnt, kind == C_RD ? BL : 0);
    if (kind == C_RD) chk("R8", "first read valid clock", rd_first, k + CL);
  endtask

  task automatic t_bad_read(int b);
    int rdv = 0;
    tick(C_RD, b, 1'b0);
    chk("R9", "read to idle bank flagged", int'(proto_err), 1);
    for (int c = 0; c < 8; c++) begin
      tick(C_NOP, 0, 1'b0);
      rdv += int'(rd_valid);
    end
    chk("R9", "refused read gives no data", rdv, 0);
    chk("R9", "refused read leaves bank idle", st(b), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_activate(0);
    t_plain_write(0);
    t_ap_write_with_refusal(0);
    t_interrupt(C_WR, 1, 1, 2);
    t_interrupt(C_RD, 2, 0, 1);
    t_interrupt(C_WR, 3, 3, 0);
    t_interrupt(C_RD, 1, 2, 3);
    t_interrupt(C_RD, 3, 1, 3);
    t_interrupt(C_WR, 2, 2, 0);
    t_bad_read(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule